// File: doc/BRIEF.md
# Unsigned Wallace Tree Multiplier

This block multiplies two unsigned operands in combinational logic and returns the full double-width product. It is meant for datapaths that need a product in the same cycle as the operands, where a single carry-propagate chain per partial product row would be too slow. No clock, reset or handshake is involved. The product follows the operands after the logic settles.

The operands first expand into a matrix of AND-gate partial product bits, grouped by binary weight into columns. Several carry-save layers then shrink every column to at most two bits. Inside a layer, each group of three bits in a column goes to a full adder and a leftover pair goes to a half adder. Sums stay in their own column and carries move one column up for the next layer, so no carry travels along a layer. The number of layers and the adder allocation in every column are computed from the operand width when the design is built, and every adder is an explicit cell. A final ripple stage adds the two remaining rows. A guard column above the product width catches any carry that would leave the product.

Top module: `wallace_mul`

## Requirements
- R1: For every pair of unsigned operands, `product` equals the exact unsigned product `op_a` times `op_b`, 2N bits wide.
- R2: Partial product bit (i, j) is `op_a[j] & op_b[i]` and has weight 2^(i+j). The design contains no multiply operator.
- R3: Each carry-save layer preserves the weighted sum of the bit matrix it receives.
- R4: Within a layer, three bits of one column go to a full adder and a remaining pair goes to a half adder. Each sum stays in its column and each carry enters the next higher column of the next layer.
- R5: Layers repeat until no column holds more than two bits. For N = 8 there are four carry-save layers, then the final adding stage, giving five stages.
- R6: The final stage never produces a bit above position 2N-1 (no overflow into the guard column or out of the carry chain).
- R7: If either operand is zero, the product is zero.
- R8: If `op_b` is 1, the product equals `op_a` zero-extended. If `op_a` is 1, the product equals `op_b` zero-extended.
- R9: 172 times 229 gives 39388 (16'b1001100111011100).
- R10: Both operands at their maximum (255 for N = 8) give 65025, the largest product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N (8) | First unsigned operand |
| op_b | input | N (8) | Second unsigned operand |
| product | output | 2N (16) | Unsigned product of the two operands |

## Verification
Assertions inside the RTL check the arithmetic at every operand change:
- the partial product matrix carries the value of a shift-and-add reference;
- every carry-save layer keeps the weighted sum of its matrix;
- the final stage receives no more than two rows and produces nothing above the product width;
- a zero operand or a unit multiplier gives the expected product.

The exact product for a given operand pair can only be shown by the bench scenarios. These are a table of corner pairs (zeros, ones, maximum, powers of two, alternating patterns and the 172 by 229 case) followed by thousands of random pairs compared against a behavioural reference.

// File: rtl/wallace_pkg.sv
// wallace_pkg: elaboration-time helpers shared by the multiplier modules.
// Computes the height of every column in every reduction layer and the
// number of carry-save layers. Assumes the operand width N is at least 3
// and that 2N+1 columns fit in MAX_COLS.
package wallace_pkg;

    localparam int MAX_COLS = 80;

    // Number of partial product bits in column k of an N-by-N matrix.
    function automatic int pp_height(input int n, input int k);
        int rise;
        int fall;
        if (k < 0 || k > n + n - 2) return 0;
        rise = k + 1;
        fall = n + n - 1 - k;
        return (rise < fall) ? rise : fall;
    endfunction

    // Full adders taken by a column holding h bits.
    function automatic int fa_count(input int h);
        return h / 3;
    endfunction

    // Half adder taken by a column holding h bits (a leftover pair).
    function automatic int ha_count(input int h);
        return (h % 3 == 2) ? 1 : 0;
    endfunction

    // Bits that pass a layer untouched (a single leftover bit).
    function automatic int pass_count(input int h);
        return (h % 3 == 1) ? 1 : 0;
    endfunction

    // Height of column k at the input of the given layer (layer 0 is the
    // partial product matrix). The top column is a guard with no adders.
    function automatic int col_height(input int n, input int layer, input int k);
        int cur [MAX_COLS];
        int nxt [MAX_COLS];
        int cols;
        int own;
        int cin;
        cols = n + n + 1;
        for (int c = 0; c < MAX_COLS; c++) begin
            cur[c] = (c < cols) ? pp_height(n, c) : 0;
            nxt[c] = 0;
        end
        for (int l = 0; l < layer; l++) begin
            for (int c = 0; c < cols; c++) begin
                if (c == cols - 1) own = cur[c];
                else own = fa_count(cur[c]) + ha_count(cur[c]) + pass_count(cur[c]);
                if (c == 0) cin = 0;
                else cin = fa_count(cur[c - 1]) + ha_count(cur[c - 1]);
                nxt[c] = own + cin;
            end
            for (int c = 0; c < cols; c++) cur[c] = nxt[c];
        end
        return cur[k];
    endfunction

    // Number of carry-save layers needed until every column holds <= 2 bits.
    function automatic int num_layers(input int n);
        int tallest;
        for (int l = 0; l < 64; l++) begin
            tallest = 0;
            for (int k = 0; k < n + n + 1; k++) begin
                if (col_height(n, l, k) > tallest) tallest = col_height(n, l, k);
            end
            if (tallest <= 2) return l;
        end
        return 64;
    endfunction

endpackage

// File: rtl/wt_half_add.sv
// wt_half_add: one-bit half adder cell. Adds two bits of equal weight,
// giving a sum of that weight and a carry of double weight.
module wt_half_add (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    // Sum and carry of two equal-weight bits.
    assign s = x ^ y;
    assign c = x & y;
endmodule

// File: rtl/wt_full_add.sv
// wt_full_add: one-bit full adder cell. Adds three bits of equal weight,
// giving a sum of that weight and a carry of double weight.
module wt_full_add (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    // Sum is the parity and carry is the majority of the three inputs.
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/wt_pp_gen.sv
// wt_pp_gen: builds the partial product matrix. Column k collects every
// AND term a[j] & b[i] with i + j = k, packed from row 0 upward; unused
// slots and the two top columns are zero. Assumes N >= 3.
module wt_pp_gen #(
    parameter int N = 8
) (
    input  logic [N-1:0]          op_a,
    input  logic [N-1:0]          op_b,
    output logic [N+N:0][N-1:0]   mat
);
    import wallace_pkg::*;

    localparam int COLS = N + N + 1;
    localparam int SW   = N + N + 4;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        localparam int H  = pp_height(N, k);
        localparam int LO = (k > N - 1) ? k - N + 1 : 0;
        for (genvar t = 0; t < N; t++) begin : g_bit
            if (t < H) begin : g_and
                // AND term whose b index is LO+t and a index is k-LO-t.
                assign mat[k][t] = op_a[k - LO - t] & op_b[LO + t];
            end else begin : g_zero
                // Empty slot above the column height.
                assign mat[k][t] = 1'b0;
            end
        end
    end

    logic [SW-1:0] mat_value;
    logic [SW-1:0] shift_add_ref;

    // Matrix value against a shift-and-add reference of the operands.
    always_comb begin
        mat_value     = '0;
        shift_add_ref = '0;
        for (int k = 0; k < COLS; k++) begin
            for (int j = 0; j < N; j++) begin
                mat_value = mat_value + (SW'(mat[k][j]) << k);
            end
        end
        for (int i = 0; i < N; i++) begin
            if (op_b[i]) shift_add_ref = shift_add_ref + (SW'(op_a) << i);
        end
        assert_pp_value_R2: assert (mat_value == shift_add_ref)
            else $error("partial product matrix value %0d, expected %0d", mat_value, shift_add_ref);
    end
endmodule

// File: rtl/wt_csa_layer.sv
// wt_csa_layer: one carry-save reduction layer. In each column, triples go
// to full adders and a leftover pair to a half adder. A single leftover bit
// passes through. Output column order: sums, passed bit, then carries from
// the column below. The top (guard) column has no adders. Column heights
// come from wallace_pkg for the given LAYER index.
module wt_csa_layer #(
    parameter int N     = 8,
    parameter int LAYER = 0
) (
    input  logic [N+N:0][N-1:0] mat_in,
    output logic [N+N:0][N-1:0] mat_out
);
    import wallace_pkg::*;

    localparam int COLS = N + N + 1;
    localparam int SW   = N + N + 4;

    for (genvar k = 0; k < COLS; k++) begin : g_col
        localparam int H     = col_height(N, LAYER, k);
        localparam int NFA   = (k < COLS - 1) ? fa_count(H) : 0;
        localparam int NHA   = (k < COLS - 1) ? ha_count(H) : 0;
        localparam int NADD  = NFA + NHA;
        localparam int USED  = NFA + NFA + NFA + NHA + NHA;
        localparam int NPASS = H - USED;
        localparam int HPREV = col_height(N, LAYER, (k > 0) ? k - 1 : 0);
        localparam int CIN   = (k > 0) ? fa_count(HPREV) + ha_count(HPREV) : 0;

        if (NADD > 0) begin : g_add
            logic [NADD-1:0] s_loc;
            logic [NADD-1:0] c_loc;
            for (genvar f = 0; f < NFA; f++) begin : g_fa
                wt_full_add u_fa (
                    .x (mat_in[k][f + f + f]),
                    .y (mat_in[k][f + f + f + 1]),
                    .z (mat_in[k][f + f + f + 2]),
                    .s (s_loc[f]),
                    .c (c_loc[f])
                );
            end
            if (NHA > 0) begin : g_ha
                wt_half_add u_ha (
                    .x (mat_in[k][USED - 2]),
                    .y (mat_in[k][USED - 1]),
                    .s (s_loc[NFA]),
                    .c (c_loc[NFA])
                );
            end
        end

        for (genvar j = 0; j < N; j++) begin : g_out
            if (j < NADD) begin : g_sum
                // Sum bits stay in this column.
                assign mat_out[k][j] = g_add.s_loc[j];
            end else if (j < NADD + NPASS) begin : g_pass
                // Leftover bit moves on unchanged.
                assign mat_out[k][j] = mat_in[k][USED + j - NADD];
            end else if (j < NADD + NPASS + CIN) begin : g_carry
                // Carries arrive from the column below.
                assign mat_out[k][j] = g_col[k-1].g_add.c_loc[j - NADD - NPASS];
            end else begin : g_zero
                // Empty slot above the new column height.
                assign mat_out[k][j] = 1'b0;
            end
        end
    end

    logic [SW-1:0] value_in;
    logic [SW-1:0] value_out;

    // The weighted sum of the matrix is preserved across the layer.
    always_comb begin
        value_in  = '0;
        value_out = '0;
        for (int k = 0; k < COLS; k++) begin
            for (int j = 0; j < N; j++) begin
                value_in  = value_in  + (SW'(mat_in[k][j])  << k);
                value_out = value_out + (SW'(mat_out[k][j]) << k);
            end
        end
        assert_layer_value_R3: assert (value_in == value_out)
            else $error("layer %0d changed matrix value %0d -> %0d", LAYER, value_in, value_out);
    end
endmodule

// File: rtl/wt_final_add.sv
// wt_final_add: carry-propagate stage. Adds the two remaining rows of the
// reduced matrix with a ripple of full adder cells over all columns,
// including the guard column. Assumes rows 2 and up are already empty.
module wt_final_add #(
    parameter int N = 8
) (
    input  logic [N+N:0][N-1:0] mat,
    output logic [N+N-1:0]      prod
);
    localparam int COLS = N + N + 1;

    logic [COLS:0]   carry;
    logic [COLS-1:0] total;

    // The chain starts without a carry.
    assign carry[0] = 1'b0;

    for (genvar k = 0; k < COLS; k++) begin : g_rip
        wt_full_add u_fa (
            .x (mat[k][0]),
            .y (mat[k][1]),
            .z (carry[k]),
            .s (total[k]),
            .c (carry[k+1])
        );
    end

    // Product is the sum without the guard column.
    assign prod = total[N+N-1:0];

    logic extra_rows;

    // Nothing beyond two rows arrives, and nothing leaves the product width.
    always_comb begin
        extra_rows = 1'b0;
        for (int k = 0; k < COLS; k++) begin
            for (int j = 2; j < N; j++) extra_rows = extra_rows | mat[k][j];
        end
        assert_two_rows_R5: assert (!extra_rows)
            else $error("final stage received more than two rows");
        assert_no_overflow_R6: assert (!total[COLS-1] && !carry[COLS])
            else $error("carry escaped product width");
    end
endmodule

// File: rtl/wallace_mul.sv
// wallace_mul: combinational N-by-N unsigned multiplier. Partial products
// are reduced by NUM_LAYERS carry-save layers to two rows, then summed by
// a ripple stage. No clock or reset; the output settles after the inputs.
// Assumes N >= 3.
module wallace_mul #(
    parameter int N = 8
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [N+N-1:0] product
);
    import wallace_pkg::*;

    localparam int COLS       = N + N + 1;
    localparam int NUM_LAYERS = num_layers(N);

    logic [COLS-1:0][N-1:0] stage_mat [NUM_LAYERS+1];

    wt_pp_gen #(.N(N)) u_pp (
        .op_a (op_a),
        .op_b (op_b),
        .mat  (stage_mat[0])
    );

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        wt_csa_layer #(.N(N), .LAYER(l)) u_layer (
            .mat_in  (stage_mat[l]),
            .mat_out (stage_mat[l+1])
        );
    end

    wt_final_add #(.N(N)) u_final (
        .mat  (stage_mat[NUM_LAYERS]),
        .prod (product)
    );

    // Zero and unit operands give the known products.
    always_comb begin
        assert_zero_operand_R7: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("zero operand gave product %0d", product);
        assert_unit_operand_R8: assert ((op_b != N'(1)) || (product == {{N{1'b0}}, op_a}))
            else $error("unit multiplier gave product %0d for %0d", product, op_a);
    end
endmodule

// File: tb/wallace_mul_tb.sv
// wallace_mul_tb: applies a vector table of operand pairs, directed corner
// cases and random pairs, comparing the product against a reference.
module wallace_mul_tb;
    localparam int N          = 8;
    localparam int NRAND      = 4000;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 14;

    // {op_a, op_b, expected product}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0,   8'd0,   16'd0},
        {8'd0,   8'd255, 16'd0},
        {8'd255, 8'd0,   16'd0},
        {8'd255, 8'd255, 16'd65025},
        {8'd1,   8'd173, 16'd173},
        {8'd173, 8'd1,   16'd173},
        {8'd128, 8'd128, 16'd16384},
        {8'd172, 8'd229, 16'd39388},
        {8'd1,   8'd1,   16'd1},
        {8'd2,   8'd128, 16'd256},
        {8'd255, 8'd1,   16'd255},
        {8'd170, 8'd85,  16'd14450},
        {8'd15,  8'd240, 16'd3600},
        {8'd128, 8'd255, 16'd32640}
    };

    logic             clk = 1'b0;
    logic [N-1:0]     op_a = '0;
    logic [N-1:0]     op_b = '0;
    logic [N+N-1:0]   product;
    int               checks = 0;
    int               errors = 0;
    bit               finished = 1'b0;

    // 250 MHz clock paces the stimulus and the watchdog.
    always #2 clk = ~clk;

    wallace_mul #(.N(N)) u_dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    // Apply a pair, let it settle away from the clock edge, compare.
    task automatic apply_check(input string tag, input logic [N-1:0] a,
                               input logic [N-1:0] b, input logic [N+N-1:0] exp);
        @(negedge clk);
        op_a = a;
        op_b = b;
        #1;
        checks++;
        if (product !== exp) begin
            errors++;
            $display("FAIL %s: %0d x %0d gave %0d, expected %0d", tag, a, b, product, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Main stimulus: table walk, directed cases, random sweep.
    initial begin
        for (int v = 0; v < NVEC; v++) begin
            apply_check("R1 table", VEC[v][31:24], VEC[v][23:16], VEC[v][15:0]);
        end
        // R7: zero in either position
        apply_check("R7 zero a", 8'd0, 8'd99, 16'd0);
        apply_check("R7 zero b", 8'd201, 8'd0, 16'd0);
        // R8: unit operand in either position
        for (int x = 0; x < 256; x += 51) begin
            apply_check("R8 unit b", N'(x), 8'd1, 16'(x));
            apply_check("R8 unit a", 8'd1, N'(x), 16'(x));
        end
        // R9: worked example
        apply_check("R9 example", 8'b10101100, 8'b11100101, 16'b1001100111011100);
        // R10: maximum operands
        apply_check("R10 max", 8'd255, 8'd255, 16'd65025);
        // R2: single-bit operands exercise each partial product weight alone
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                apply_check("R2 weight", N'(1) << j, N'(1) << i, (N+N)'(1) << (i + j));
            end
        end
        // R1/R3/R4/R5/R6: random pairs against a behavioural product
        for (int r = 0; r < NRAND; r++) begin
            logic [N-1:0] ra;
            logic [N-1:0] rb;
            ra = N'($urandom);
            rb = N'($urandom);
            apply_check("R1/R3/R4/R5/R6 random", ra, rb, (N+N)'(ra) * (N+N)'(rb));
        end
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            finish_run();
        end
    end
endmodule